// File: doc/BRIEF.md
# SPI Master Transfer Controller

This block runs the serial side of an SPI master for one transfer at a time. The host writes a set of control inputs and the transfer lengths, then pulses a start bit. The engine then runs `total_len_i` bursts of eight bits each. Each of the first `tx_len_i` bursts takes one byte from the host through a valid/ready handshake. Each remaining burst is a dummy burst that shifts out a constant bit. Every burst also shifts in one byte from MISO, and that byte goes back to the host as a one-cycle strobe.

The control inputs set the following:
- SCLK phase and polarity.
- Bit order.
- The dummy bit value.
- Whether receive bytes that arrive while real transmit data goes out are discarded.
- Whether MISO is captured one system clock after the nominal SCLK edge.
- Chip-select behaviour: polarity, which of four lines is used, whether the line is negated between bursts, and whether software owns the line and drives it to a chosen level.

SCLK is a fixed division of the system clock, with a half period of `HALF_DIV` system clocks. `HALF_DIV` must be at least 2. Shift-side controls are latched at start. The chip-select controls act live and must be held stable while `busy_o` is high.

Top module: `spi_xfer_ctrl`

## Requirements
- R1: A `start_i` pulse while idle with `total_len_i` nonzero raises `busy_o` on the next cycle. `busy_o` stays high until the last burst has completed, then returns to 0.
- R2: While idle, `sclk_o` equals `cpol_i`, where 0 means SCLK idles low and 1 means SCLK idles high. Each burst has exactly 8 leading edges, each SCLK level lasts `HALF_DIV` system clocks, and SCLK returns to its idle level after each burst.
- R3: With `cpha_i`=0, MOSI is valid before the leading edge, MISO is sampled on the leading edge, and MOSI changes on the trailing edge. With `cpha_i`=1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R4: With `lsb_first_i`=0, bit 7 is sent and received first. With `lsb_first_i`=1, bit 0 is first. The setting applies to both directions.
- R5: Bursts with index below min(`tx_len_i`, `total_len_i`) each consume one host byte, accepted on a cycle where `tx_valid_i` and `tx_ready_o` are both high. All later bursts send all bits equal to `dummy_val_i`.
- R6: Each burst ends with one single-cycle `rx_valid_o` pulse carrying the received byte. When `drop_i`=1, bursts that carry host transmit data produce no pulse.
- R7: In controller mode (`cs_sw_own_i`=0), line `cs_sel_i` (0 to 3) is asserted during each burst. The asserted level is high when `cs_pol_i`=0 and low when `cs_pol_i`=1. Unselected lines always sit at the inactive level, which equals `cs_pol_i`.
- R8: With `cs_gap_i`=0, the selected line stays asserted across all bursts of a transfer. With `cs_gap_i`=1, the line is negated between consecutive bursts, giving `total_len_i`−1 negations within a transfer.
- R9: With `cs_sw_own_i`=1, the selected line follows `cs_sw_lvl_i` directly, one cycle later, whatever the transfer state. The other lines stay inactive.
- R10: With `late_sample_i`=1, MISO is captured one system clock after the nominal sample edge. A slave whose data becomes valid only just after that edge is then read correctly.
- R11: A start pulse with `total_len_i`=0 is ignored. A start pulse while busy has no effect on the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Exchange start pulse |
| total_len_i | input | LEN_W | Total bursts in the transfer |
| tx_len_i | input | LEN_W | Bursts carrying host transmit data |
| cpha_i | input | 1 | Clock phase |
| cpol_i | input | 1 | Clock polarity (SCLK idle level) |
| lsb_first_i | input | 1 | Bit order: 1 = LSB first |
| dummy_val_i | input | 1 | Bit value of dummy bursts |
| drop_i | input | 1 | Discard receive bytes of transmit bursts |
| late_sample_i | input | 1 | Capture MISO one clock late |
| cs_gap_i | input | 1 | Negate chip select between bursts |
| cs_pol_i | input | 1 | Chip-select polarity: 1 = active low |
| cs_sel_i | input | 2 | Selected chip-select line |
| cs_sw_own_i | input | 1 | Software owns the chip select |
| cs_sw_lvl_i | input | 1 | Software chip-select level |
| busy_o | output | 1 | Exchange bit readback |
| tx_data_i | input | BW | Host transmit byte |
| tx_valid_i | input | 1 | Host transmit byte valid |
| tx_ready_o | output | 1 | Engine ready for transmit byte |
| rx_data_o | output | BW | Received byte |
| rx_valid_o | output | 1 | Received byte strobe |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | CS_N | Chip-select lines |

## Verification
The bench plays the slave. It drives MISO only on its own shift edges and records MOSI on its sample edges, so the data checks fail if the design mixes up which edge samples and which edge shifts (R3), or reverses the bit order in only one direction (R4).

A second slave model presents each bit only after the sample edge has passed. Read through that model, a design that ignores the late-sample control returns every byte shifted by one bit.

Mixed transmit and dummy lengths, including a transmit count longer than the transfer, catch a design that pulls too many host bytes, sends the wrong dummy constant, or discards the wrong set of receive bytes.

Counting chip-select negations while busy exposes a line that drops between bursts when it should hold. Restarting mid-transfer and starting with zero length expose an engine that re-arms when it should not.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TAIL,
    ST_GAP
  } seq_st_e;

  typedef struct packed {
    logic cpha;
    logic cpol;
    logic lsb_first;
    logic dummy_val;
    logic drop;
    logic late;
    logic cs_gap;
  } xfer_cfg_t;

endpackage

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq
  import spi_xfer_pkg::*;
#(
  parameter int BW       = 8,
  parameter int LEN_W    = 8,
  parameter int HALF_DIV = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] total_len_i,
  input  logic [LEN_W-1:0] tx_len_i,
  input  xfer_cfg_t        cfg_i,
  input  logic             tx_valid_i,
  output xfer_cfg_t        cfg_o,
  output logic             busy_o,
  output logic             tx_ready_o,
  output logic             load_o,
  output logic             load_dummy_o,
  output logic             shift_o,
  output logic             sample_o,
  output logic             sclk_act_o,
  output logic             cs_act_o,
  output logic             deliver_o,
  output logic             keep_o
);

  localparam int EDGE_N = 2 * BW;
  localparam int EDGE_W = $clog2(EDGE_N);
  localparam int DIV_W  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(HALF_DIV - 1);
  localparam logic [EDGE_W-1:0] EDGE_LAST = EDGE_W'(EDGE_N - 1);

  seq_st_e           st_q;
  logic [DIV_W-1:0]  div_q;
  logic [EDGE_W-1:0] edge_q;
  logic [LEN_W-1:0]  idx_q, tot_q, txl_q;
  xfer_cfg_t         cfg_q;
  logic              have_q, sclk_q;

  logic half_done, need_tx, edge_now, smp_edge, last_burst;

  assign half_done  = (div_q == DIV_LAST);
  assign need_tx    = (idx_q < txl_q);
  assign last_burst = (idx_q == tot_q - LEN_W'(1));
  assign edge_now   = (st_q == ST_SHIFT) && half_done;
  // even edges lead, odd edges trail
  assign smp_edge   = cfg_q.cpha ? edge_q[0] : ~edge_q[0];

  assign tx_ready_o   = (st_q == ST_LEAD) && need_tx && !have_q;
  assign load_o       = (st_q == ST_LEAD) && !have_q && (!need_tx || tx_valid_i);
  assign load_dummy_o = !need_tx;
  assign sample_o     = edge_now && smp_edge;
  assign shift_o      = edge_now && !smp_edge && (edge_q != '0);
  assign deliver_o    = (st_q == ST_TAIL) && half_done;
  assign keep_o       = !(cfg_q.drop && need_tx);
  assign cs_act_o     = (st_q == ST_LEAD) || (st_q == ST_SHIFT) || (st_q == ST_TAIL);
  assign busy_o       = (st_q != ST_IDLE);
  assign sclk_act_o   = sclk_q;
  assign cfg_o        = cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      div_q  <= '0;
      edge_q <= '0;
      idx_q  <= '0;
      tot_q  <= '0;
      txl_q  <= '0;
      cfg_q  <= '0;
      have_q <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i && (total_len_i != '0)) begin
            st_q   <= ST_LEAD;
            tot_q  <= total_len_i;
            txl_q  <= (tx_len_i > total_len_i) ? total_len_i : tx_len_i;
            cfg_q  <= cfg_i;
            idx_q  <= '0;
            div_q  <= '0;
            have_q <= 1'b0;
            sclk_q <= 1'b0;
          end
        end
        ST_LEAD: begin
          if (load_o) have_q <= 1'b1;
          if (have_q) begin
            if (half_done) begin
              div_q  <= '0;
              edge_q <= '0;
              st_q   <= ST_SHIFT;
            end else begin
              div_q <= div_q + DIV_W'(1);
            end
          end
        end
        ST_SHIFT: begin
          if (half_done) begin
            div_q  <= '0;
            sclk_q <= ~sclk_q;
            if (edge_q == EDGE_LAST) begin
              edge_q <= '0;
              st_q   <= ST_TAIL;
            end else begin
              edge_q <= edge_q + EDGE_W'(1);
            end
          end else begin
            div_q <= div_q + DIV_W'(1);
          end
        end
        ST_TAIL: begin
          if (half_done) begin
            div_q  <= '0;
            have_q <= 1'b0;
            if (last_burst) begin
              st_q <= ST_IDLE;
            end else begin
              idx_q <= idx_q + LEN_W'(1);
              st_q  <= cfg_q.cs_gap ? ST_GAP : ST_LEAD;
            end
          end else begin
            div_q <= div_q + DIV_W'(1);
          end
        end
        ST_GAP: begin
          if (half_done) begin
            div_q <= '0;
            st_q  <= ST_LEAD;
          end else begin
            div_q <= div_q + DIV_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_SCLK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$stable(sclk_q)) |=> $stable(sclk_q)); // R2

  AST_READY_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> (cs_act_o && !sclk_q)); // R5

endmodule

// File: rtl/spi_xfer_dp.sv
module spi_xfer_dp
  import spi_xfer_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  xfer_cfg_t     cfg_i,
  input  logic          load_i,
  input  logic          load_dummy_i,
  input  logic [BW-1:0] tx_data_i,
  input  logic          shift_i,
  input  logic          sample_i,
  input  logic          miso_i,
  input  logic          deliver_i,
  input  logic          keep_i,
  output logic          mosi_o,
  output logic [BW-1:0] rx_data_o,
  output logic          rx_valid_o
);

  logic [BW-1:0] tx_sh_q, rx_sh_q;
  logic          pend_q, cap_en;

  assign mosi_o = cfg_i.lsb_first ? tx_sh_q[0] : tx_sh_q[BW-1];
  // late mode: capture one system clock after the nominal edge
  assign cap_en = cfg_i.late ? pend_q : sample_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh_q <= '0;
    end else if (load_i) begin
      tx_sh_q <= load_dummy_i ? {BW{cfg_i.dummy_val}} : tx_data_i;
    end else if (shift_i) begin
      tx_sh_q <= cfg_i.lsb_first ? {1'b0, tx_sh_q[BW-1:1]} : {tx_sh_q[BW-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      rx_sh_q <= '0;
    end else begin
      pend_q <= sample_i && cfg_i.late;
      if (cap_en) begin
        rx_sh_q <= cfg_i.lsb_first ? {miso_i, rx_sh_q[BW-1:1]} : {rx_sh_q[BW-2:0], miso_i};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= deliver_i && keep_i;
      if (deliver_i) rx_data_o <= rx_sh_q;
    end
  end

  AST_RX_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o); // R6

  AST_NO_CAP_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !(shift_i || sample_i)); // R3

endmodule

// File: rtl/spi_xfer_cs.sv
module spi_xfer_cs #(
  parameter int CS_N  = 4,
  parameter int SEL_W = $clog2(CS_N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_act_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             pol_i,
  input  logic             sw_own_i,
  input  logic             sw_lvl_i,
  output logic [CS_N-1:0]  cs_o
);

  for (genvar g = 0; g < CS_N; g++) begin : g_line
    logic on_line, lvl_d;
    assign on_line = (sel_i == SEL_W'(g));
    always_comb begin
      if (!on_line)      lvl_d = pol_i;
      else if (sw_own_i) lvl_d = sw_lvl_i;
      else               lvl_d = cs_act_i ? ~pol_i : pol_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cs_o[g] <= 1'b0;
      else         cs_o[g] <= lvl_d;
    end

    AST_CS_IDLE_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i != SEL_W'(g)) |=> (cs_o[g] == $past(pol_i))); // R7

    AST_CS_SW_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sw_own_i && sel_i == SEL_W'(g)) |=> (cs_o[g] == $past(sw_lvl_i))); // R9
  end

endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
  import spi_xfer_pkg::*;
#(
  parameter int BW       = 8,
  parameter int LEN_W    = 8,
  parameter int CS_N     = 4,
  parameter int HALF_DIV = 2,
  parameter int SEL_W    = $clog2(CS_N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] total_len_i,
  input  logic [LEN_W-1:0] tx_len_i,
  input  logic             cpha_i,
  input  logic             cpol_i,
  input  logic             lsb_first_i,
  input  logic             dummy_val_i,
  input  logic             drop_i,
  input  logic             late_sample_i,
  input  logic             cs_gap_i,
  input  logic             cs_pol_i,
  input  logic [SEL_W-1:0] cs_sel_i,
  input  logic             cs_sw_own_i,
  input  logic             cs_sw_lvl_i,
  output logic             busy_o,
  input  logic [BW-1:0]    tx_data_i,
  input  logic             tx_valid_i,
  output logic             tx_ready_o,
  output logic [BW-1:0]    rx_data_o,
  output logic             rx_valid_o,
  output logic             sclk_o,
  output logic             mosi_o,
  input  logic             miso_i,
  output logic [CS_N-1:0]  cs_o
);

  xfer_cfg_t cfg_live, cfg_run;
  logic load, load_dummy, shift, sample, sclk_act, cs_act, deliver, keep;

  assign cfg_live = '{cpha: cpha_i, cpol: cpol_i, lsb_first: lsb_first_i,
                      dummy_val: dummy_val_i, drop: drop_i, late: late_sample_i,
                      cs_gap: cs_gap_i};

  spi_xfer_seq #(.BW(BW), .LEN_W(LEN_W), .HALF_DIV(HALF_DIV)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .total_len_i  (total_len_i),
    .tx_len_i     (tx_len_i),
    .cfg_i        (cfg_live),
    .tx_valid_i   (tx_valid_i),
    .cfg_o        (cfg_run),
    .busy_o       (busy_o),
    .tx_ready_o   (tx_ready_o),
    .load_o       (load),
    .load_dummy_o (load_dummy),
    .shift_o      (shift),
    .sample_o     (sample),
    .sclk_act_o   (sclk_act),
    .cs_act_o     (cs_act),
    .deliver_o    (deliver),
    .keep_o       (keep)
  );

  spi_xfer_dp #(.BW(BW)) u_dp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_i        (cfg_run),
    .load_i       (load),
    .load_dummy_i (load_dummy),
    .tx_data_i    (tx_data_i),
    .shift_i      (shift),
    .sample_i     (sample),
    .miso_i       (miso_i),
    .deliver_i    (deliver),
    .keep_i       (keep),
    .mosi_o       (mosi_o),
    .rx_data_o    (rx_data_o),
    .rx_valid_o   (rx_valid_o)
  );

  spi_xfer_cs #(.CS_N(CS_N), .SEL_W(SEL_W)) u_cs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_act_i (cs_act),
    .sel_i    (cs_sel_i),
    .pol_i    (cs_pol_i),
    .sw_own_i (cs_sw_own_i),
    .sw_lvl_i (cs_sw_lvl_i),
    .cs_o     (cs_o)
  );

  assign sclk_o = (busy_o ? cfg_run.cpol : cpol_i) ^ sclk_act;

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && total_len_i != '0) |=> busy_o); // R1

  AST_ZERO_LEN_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && total_len_i == '0) |=> !busy_o); // R11

  AST_SCLK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (sclk_o == cpol_i)); // R2

  AST_RX_IN_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(busy_o)); // R6

endmodule

// File: tb/sim_spi_xfer_ctrl.sv
`timescale 1ns/1ps
module sim_spi_xfer_ctrl;

  localparam int BW = 8, LEN_W = 8, CS_N = 4, HALF_DIV = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic start = 0;
  logic [LEN_W-1:0] tot_len = 0, tx_len = 0;
  logic c_cpha = 0, c_cpol = 0, c_lsb = 0, c_dummy = 0, c_drop = 0, c_late = 0;
  logic c_gap = 0, c_pol = 0, c_own = 0, c_lvl = 0;
  logic [1:0] c_sel = 0;
  logic busy, tx_ready, rx_valid, sclk, mosi, miso = 0, tx_valid = 0;
  logic [BW-1:0] tx_data = 0, rx_data;
  logic [CS_N-1:0] cs;

  spi_xfer_ctrl #(.BW(BW), .LEN_W(LEN_W), .CS_N(CS_N), .HALF_DIV(HALF_DIV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .total_len_i(tot_len), .tx_len_i(tx_len),
    .cpha_i(c_cpha), .cpol_i(c_cpol), .lsb_first_i(c_lsb), .dummy_val_i(c_dummy),
    .drop_i(c_drop), .late_sample_i(c_late), .cs_gap_i(c_gap), .cs_pol_i(c_pol),
    .cs_sel_i(c_sel), .cs_sw_own_i(c_own), .cs_sw_lvl_i(c_lvl), .busy_o(busy),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .sclk_o(sclk), .mosi_o(mosi),
    .miso_i(miso), .cs_o(cs));

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // slave model and monitors
  logic [7:0] s_tx [16], m_rec [16], exp_tx [16], r_cap [16];
  bit mon_en = 0, slow = 0, prev_sclk = 0, prev_asrt = 0, hs_pend = 0;
  int s_smp = 0, s_byte = 0, r_n = 0, lead_n = 0, deassert_n = 0;
  int other_bad = 0, sw_bad = 0, tx_ptr = 0, tx_eff = 0;

  function automatic logic sbit(input int b, input int k);
    return c_lsb ? s_tx[b & 15][k] : s_tx[b & 15][7-k];
  endfunction

  always @(negedge clk) begin
    if (mon_en) begin
      if (sclk != prev_sclk) begin
        bit lead, smp;
        lead = (sclk != c_cpol);
        smp  = c_cpha ? !lead : lead;
        if (lead) lead_n++;
        if (smp) begin
          m_rec[s_byte & 15][c_lsb ? s_smp : 7 - s_smp] = mosi;
          if (slow) miso = sbit(s_byte, s_smp);
          s_smp++;
          if (s_smp == 8) begin s_smp = 0; s_byte++; end
        end else if (!slow) begin
          miso = sbit(s_byte, s_smp);
        end
      end
      prev_sclk = sclk;
      if (rx_valid) begin r_cap[r_n & 15] = rx_data; r_n++; end
      if (hs_pend) tx_ptr++;
      tx_data  = exp_tx[tx_ptr & 15];
      tx_valid = (tx_ptr < tx_eff);
      hs_pend  = tx_valid && tx_ready;
      for (int g = 0; g < CS_N; g++)
        if (g != int'(c_sel) && cs[g] != c_pol) other_bad++;
      if (c_own) begin
        if (cs[c_sel] != c_lvl) sw_bad++;
      end else begin
        if (busy && prev_asrt && cs[c_sel] == c_pol) deassert_n++;
        prev_asrt = (cs[c_sel] != c_pol);
      end
    end
  end

  task automatic run_xfer(input int tot, input int txl, input bit restart);
    int exp_rx, k, c;
    logic [7:0] exp_m;
    @(negedge clk);
    tot_len = LEN_W'(tot);
    tx_len  = LEN_W'(txl);
    for (int i = 0; i < 16; i++) begin
      s_tx[i]   = 8'($urandom);
      exp_tx[i] = 8'($urandom);
      m_rec[i]  = 8'h00;
      r_cap[i]  = 8'h00;
    end
    tx_eff = (txl < tot) ? txl : tot;
    @(negedge clk);
    s_smp = 0; s_byte = 0; r_n = 0; lead_n = 0; deassert_n = 0;
    other_bad = 0; sw_bad = 0; tx_ptr = 0; hs_pend = 0;
    prev_sclk = sclk; prev_asrt = 0;
    miso = slow ? 1'b0 : sbit(0, 0);
    tx_data = exp_tx[0]; tx_valid = (tx_eff > 0);
    mon_en = 1; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1'b1, "R1", "busy after start", busy, 1);
    c = 0;
    while (busy && c < 4000) begin
      if (restart && c == 10) start = 1; else start = 0;
      @(negedge clk);
      c++;
    end
    start = 0;
    chk(busy == 1'b0, "R1", "busy clears", busy, 0);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R11", "no re-arm after end", busy, 0);
    mon_en = 0;
    chk(sclk == c_cpol, "R2", "sclk idle", sclk, c_cpol);
    chk(lead_n == 8 * tot, "R2", "leading edges", lead_n, 8 * tot);
    chk(tx_ptr == tx_eff, "R5", "host bytes taken", tx_ptr, tx_eff);
    for (int i = 0; i < tot; i++) begin
      exp_m = (i < tx_eff) ? exp_tx[i] : {8{c_dummy}};
      chk(m_rec[i] == exp_m, "R3 R4 R5", $sformatf("mosi byte %0d", i), m_rec[i], exp_m);
    end
    exp_rx = c_drop ? tot - tx_eff : tot;
    chk(r_n == exp_rx, "R6", "rx count", r_n, exp_rx);
    k = 0;
    for (int i = 0; i < tot; i++) begin
      if (!(c_drop && i < tx_eff)) begin
        chk(r_cap[k & 15] == s_tx[i], "R6 R10 R4", $sformatf("rx byte %0d", i), r_cap[k & 15], s_tx[i]);
        k++;
      end
    end
    chk(other_bad == 0, "R7", "unselected lines", other_bad, 0);
    if (c_own) chk(sw_bad == 0, "R9", "sw level held", sw_bad, 0);
    else chk(deassert_n == (c_gap ? tot - 1 : 0), "R8", "cs negations", deassert_n, c_gap ? tot - 1 : 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(busy == 0 && cs == '0 && rx_valid == 0 && tx_ready == 0, "R1", "reset state",
        {busy, cs, rx_valid, tx_ready}, 0);
    chk(sclk == c_cpol, "R2", "sclk in reset", sclk, c_cpol);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // directed: all phase/polarity/order modes
    for (int m = 0; m < 8; m++) begin
      c_cpha = m[0]; c_cpol = m[1]; c_lsb = m[2]; c_sel = 2'(m);
      c_pol = m[0] ^ m[2]; c_gap = m[1]; c_dummy = m[2];
      run_xfer(3, 2, 0);
    end
    // R5: tx count larger than total, zero tx count
    c_drop = 0; run_xfer(2, 7, 0);
    c_dummy = 1; run_xfer(4, 0, 0);
    // R6: discard window
    c_drop = 1; run_xfer(5, 2, 0);
    c_drop = 1; run_xfer(3, 3, 0);
    c_drop = 0;
    // R10: slow slave needs late capture, both phases
    c_late = 1; slow = 1; c_cpha = 0; run_xfer(3, 1, 0);
    c_cpha = 1; c_lsb = 1; run_xfer(3, 1, 0);
    slow = 0; run_xfer(2, 2, 0);
    c_late = 0;
    // R11: restart while busy ignored; zero length ignored
    run_xfer(4, 2, 1);
    @(negedge clk);
    tot_len = 0; start = 1;
    @(negedge clk);
    start = 0;
    repeat (2) @(negedge clk);
    chk(busy == 0, "R11", "zero length start", busy, 0);

    // R9: software ownership, static and during a transfer
    c_own = 1;
    for (int m = 0; m < 8; m++) begin
      c_sel = 2'(m); c_lvl = m[2]; c_pol = m[0];
      repeat (2) @(negedge clk);
      chk(cs[c_sel] == c_lvl, "R9", "sw line level", cs[c_sel], c_lvl);
      for (int g = 0; g < CS_N; g++)
        if (g != m % 4) chk(cs[g] == c_pol, "R9", "sw other line", cs[g], c_pol);
    end
    c_lvl = 1; run_xfer(2, 1, 0);
    c_own = 0; c_lvl = 0;

    // constrained random
    for (int t = 0; t < 24; t++) begin
      c_cpha = 1'($urandom); c_cpol = 1'($urandom); c_lsb = 1'($urandom);
      c_dummy = 1'($urandom); c_drop = 1'($urandom); c_late = 1'($urandom);
      c_gap = 1'($urandom); c_pol = 1'($urandom); c_sel = 2'($urandom);
      slow = c_late & 1'($urandom);
      run_xfer(int'($urandom_range(1, 6)), int'($urandom_range(0, 7)), 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule